// File: doc/BRIEF.md
# Fault-Triggered Multichannel Sampling Sequencer

This block paces periodic analog acquisition for a protection-grade monitoring board. A free-running interval timer, derived from the clock frequency and the interval length in microseconds, produces one sampling tick per interval. On each tick the block runs a fixed three-step handshake with the external front end. First it turns on every analog multiplexer device together. Next it presents the channel address. Last it issues a single-cycle conversion start to the external ADC. It then waits for end-of-conversion and raises a one-cycle ready strobe so the host can collect the result.

Samples are grouped into acquisition cycles. A normal cycle is short. A fault cycle is longer and is entered in one of two ways: an external fault synchronization input, or a fresh conversion result that exceeds a threshold supplied on a port. After the last fault sample the block returns to normal mode on its own. An external acquisition sync pulse restarts both the interval timer and the sample index, so several acquisition boards can be kept in phase. If a tick arrives while a conversion is still outstanding, that tick is dropped and a sticky overrun flag is set.

Top module: `acq_seq_top`

## Requirements
- R1: While no conversion is pending, a conversion sequence starts once every TICK_CYCLES = CLK_HZ/1e6*INTERVAL_US clock cycles, so consecutive `adc_start` pulses are exactly TICK_CYCLES cycles apart.
- R2: After a tick, all MUX_N bits of `mux_en` go high in the next cycle and stay high until the conversion completes. `mux_addr` takes its new value in the second cycle. `adc_start` is high for exactly one cycle, in the third cycle, and `mux_en` is held high throughout.
- R3: The address used for a conversion is the current in-cycle sample index (`sample_idx`) modulo 2^ADDR_W, and it stays stable while `adc_start` is high.
- R4: `sample_rdy` is high for exactly one cycle, in the cycle after `adc_eoc` is seen during a pending conversion.
- R5: In normal mode (`fault_mode`=0) a cycle holds NORM_SAMPLES samples. `sample_idx` advances with each `sample_rdy`. On the last sample it returns to 0, and `cycle_done` is high alongside `sample_rdy`.
- R6: A high `fault_sync` in normal mode sets `fault_mode` and clears `sample_idx` on the next clock edge. While `fault_mode` is already 1, `fault_sync` has no effect.
- R7: In normal mode, a completed conversion whose `adc_data` is strictly greater than `threshold` enters fault mode with `sample_idx`=0, in the same cycle as its `sample_rdy`. A result equal to `threshold` does not.
- R8: A fault cycle holds FAULT_SAMPLES samples. On the last one, `cycle_done` pulses, `sample_idx` returns to 0 and `fault_mode` clears.
- R9: `acq_sync` sampled high at a clock edge restarts the interval timer and clears `sample_idx`. The next `adc_start` appears TICK_CYCLES+2 edges after that edge, so it is observed in the (TICK_CYCLES+3)-th cycle.
- R10: A tick that arrives while a conversion is pending starts no conversion and sets `overrun`. `overrun` then stays 1 until reset.
- R11: While `rst` is high, `mux_en`, `adc_start`, `sample_rdy`, `cycle_done`, `fault_mode`, `overrun` and `sample_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_sync | input | 1 | Acquisition alignment pulse from the host |
| fault_sync | input | 1 | External fault-start synchronization |
| threshold | input | DATA_W | Setting value for the over-threshold compare |
| adc_eoc | input | 1 | ADC end-of-conversion |
| adc_data | input | DATA_W | ADC result, valid with `adc_eoc` |
| mux_en | output | MUX_N | Enables for the multiplexer devices |
| mux_addr | output | ADDR_W | Multiplexer channel address |
| adc_start | output | 1 | Single-cycle conversion start/select |
| sample_rdy | output | 1 | One-cycle sample-ready strobe |
| cycle_done | output | 1 | Last sample of the current cycle |
| fault_mode | output | 1 | 1 while a fault cycle is running |
| sample_idx | output | clog2(max(NORM_SAMPLES,FAULT_SAMPLES)) | Samples taken in the current cycle |
| overrun | output | 1 | Sticky dropped-tick flag |

## Verification
The bench builds the block with CLK_HZ=1000000 and INTERVAL_US=20, which gives a 20-cycle interval, so exact tick spacing and the sync-to-start latency can be counted cycle by cycle. NORM_SAMPLES=6 and FAULT_SAMPLES=10 keep whole normal and fault cycles short. With ADDR_W=3, the fault index passes 8, so the modulo address wrap is exercised. A behavioural ADC that can hold back end-of-conversion makes it possible to force a dropped tick.

// File: rtl/acq_seq_pkg.sv
`timescale 1ns/1ps
package acq_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUXEN,
        ST_ADDR,
        ST_CONV,
        ST_WAIT
    } conv_state_e;

    typedef struct packed {
        logic done;    // conversion finished this cycle
        logic exceed;  // result above the setting value
    } sample_evt_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned idx_w(input int unsigned n, input int unsigned f);
        return $clog2(max_u(max_u(n, f), 2));
    endfunction

    function automatic int unsigned interval_cycles(input int unsigned clk_hz,
                                                    input int unsigned us);
        return (clk_hz / 1000000) * us;
    endfunction

endpackage

// File: rtl/acq_tick_timer.sv
`timescale 1ns/1ps
module acq_tick_timer #(
    parameter int unsigned TICK_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_i,
    output logic tick_o
);
    localparam int unsigned TW = $clog2(TICK_CYCLES);
    localparam logic [TW-1:0] LAST = TW'(TICK_CYCLES - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || sync_i)     cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    assign tick_o = (cnt == LAST) && !sync_i;

    // R9: an alignment pulse restarts the interval count
    a_r9_sync_restart: assert property (@(posedge clk) disable iff (rst)
        sync_i |=> (cnt == '0));

    // R1: ticks are isolated single-cycle events
    a_r1_tick_single: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
endmodule

// File: rtl/acq_conv_fsm.sv
`timescale 1ns/1ps
module acq_conv_fsm
    import acq_seq_pkg::*;
#(
    parameter int unsigned MUX_N = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             eoc_i,
    output logic [MUX_N-1:0] mux_en_o,
    output logic             latch_addr_o,
    output logic             adc_start_o,
    output logic             done_o,
    output logic             rdy_o,
    output logic             overrun_o
);
    conv_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            rdy_o     <= 1'b0;
            overrun_o <= 1'b0;
        end else begin
            rdy_o <= done_o;
            if (tick_i && state != ST_IDLE) overrun_o <= 1'b1;
            case (state)
                ST_IDLE:  if (tick_i) state <= ST_MUXEN;
                ST_MUXEN: state <= ST_ADDR;
                ST_ADDR:  state <= ST_CONV;
                ST_CONV:  state <= ST_WAIT;
                ST_WAIT:  if (eoc_i) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign mux_en_o     = {MUX_N{state != ST_IDLE}};
    assign latch_addr_o = (state == ST_MUXEN);
    assign adc_start_o  = (state == ST_CONV);
    assign done_o       = (state == ST_WAIT) && eoc_i;

    // R2: start only follows the address step
    a_r2_start_after_addr: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CONV) |-> ($past(state) == ST_ADDR));

    // R4: ready strobe lasts one cycle
    a_r4_rdy_pulse: assert property (@(posedge clk) disable iff (rst)
        rdy_o |=> !rdy_o);

    // R10: overrun is sticky
    a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun_o |=> overrun_o);

    // R10: a tick while busy never restarts the sequence
    a_r10_skip_tick: assert property (@(posedge clk) disable iff (rst)
        (tick_i && state == ST_WAIT && !eoc_i) |=> (state == ST_WAIT));
endmodule

// File: rtl/acq_mode_ctl.sv
`timescale 1ns/1ps
module acq_mode_ctl
    import acq_seq_pkg::*;
#(
    parameter int unsigned NORM_SAMPLES  = 36,
    parameter int unsigned FAULT_SAMPLES = 100,
    parameter int unsigned CNT_W         = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_i,
    input  logic             fault_sync_i,
    input  sample_evt_t      evt_i,
    output logic             fault_o,
    output logic [CNT_W-1:0] idx_o,
    output logic             cycle_done_o
);
    localparam logic [CNT_W-1:0] NORM_LAST  = CNT_W'(NORM_SAMPLES - 1);
    localparam logic [CNT_W-1:0] FAULT_LAST = CNT_W'(FAULT_SAMPLES - 1);

    logic [CNT_W-1:0] limit;
    logic             enter_fault;

    assign limit       = fault_o ? FAULT_LAST : NORM_LAST;
    assign enter_fault = !fault_o && (fault_sync_i || (evt_i.done && evt_i.exceed));

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_o      <= 1'b0;
            idx_o        <= '0;
            cycle_done_o <= 1'b0;
        end else begin
            cycle_done_o <= 1'b0;
            if (enter_fault) begin
                fault_o <= 1'b1;
                idx_o   <= '0;
            end else if (evt_i.done) begin
                if (idx_o == limit) begin
                    idx_o        <= '0;
                    cycle_done_o <= 1'b1;
                    fault_o      <= 1'b0;
                end else begin
                    idx_o <= idx_o + 1'b1;
                end
            end
            if (sync_i) idx_o <= '0;
        end
    end

    // R5: normal index stays inside the normal cycle
    a_r5_norm_bound: assert property (@(posedge clk) disable iff (rst)
        !fault_o |-> (idx_o <= NORM_LAST));

    // R8: fault index stays inside the fault cycle
    a_r8_fault_bound: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> (idx_o <= FAULT_LAST));

    // R6: entering fault mode starts the count afresh
    a_r6_entry_clears: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_o) |-> (idx_o == '0));

    // R8: leaving fault mode coincides with cycle completion
    a_r8_exit_done: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_o) |-> cycle_done_o);
endmodule

// File: rtl/acq_seq_top.sv
`timescale 1ns/1ps
module acq_seq_top
    import acq_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ        = 50000000,
    parameter int unsigned INTERVAL_US   = 200,
    parameter int unsigned NORM_SAMPLES  = 36,
    parameter int unsigned FAULT_SAMPLES = 100,
    parameter int unsigned MUX_N         = 4,
    parameter int unsigned ADDR_W        = 3,
    parameter int unsigned DATA_W        = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acq_sync,
    input  logic              fault_sync,
    input  logic [DATA_W-1:0] threshold,
    input  logic              adc_eoc,
    input  logic [DATA_W-1:0] adc_data,
    output logic [MUX_N-1:0]  mux_en,
    output logic [ADDR_W-1:0] mux_addr,
    output logic              adc_start,
    output logic              sample_rdy,
    output logic              cycle_done,
    output logic              fault_mode,
    output logic [acq_seq_pkg::idx_w(NORM_SAMPLES, FAULT_SAMPLES)-1:0] sample_idx,
    output logic              overrun
);
    localparam int unsigned TICK_CYCLES = interval_cycles(CLK_HZ, INTERVAL_US);
    localparam int unsigned CNT_W       = idx_w(NORM_SAMPLES, FAULT_SAMPLES);

    logic        tick;
    logic        latch_addr;
    logic        conv_done;
    sample_evt_t evt;

    acq_tick_timer #(.TICK_CYCLES(TICK_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .sync_i (acq_sync),
        .tick_o (tick)
    );

    acq_conv_fsm #(.MUX_N(MUX_N)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick),
        .eoc_i        (adc_eoc),
        .mux_en_o     (mux_en),
        .latch_addr_o (latch_addr),
        .adc_start_o  (adc_start),
        .done_o       (conv_done),
        .rdy_o        (sample_rdy),
        .overrun_o    (overrun)
    );

    assign evt.done   = conv_done;
    assign evt.exceed = (adc_data > threshold);

    acq_mode_ctl #(
        .NORM_SAMPLES  (NORM_SAMPLES),
        .FAULT_SAMPLES (FAULT_SAMPLES),
        .CNT_W         (CNT_W)
    ) u_mode (
        .clk          (clk),
        .rst          (rst),
        .sync_i       (acq_sync),
        .fault_sync_i (fault_sync),
        .evt_i        (evt),
        .fault_o      (fault_mode),
        .idx_o        (sample_idx),
        .cycle_done_o (cycle_done)
    );

    always_ff @(posedge clk) begin
        if (rst)             mux_addr <= '0;
        else if (latch_addr) mux_addr <= ADDR_W'(sample_idx);
    end

    // R2: every multiplexer is enabled before and during the start pulse
    a_r2_en_held: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> ((&mux_en) && $past(&mux_en)));

    // R3: address is settled before the start pulse
    a_r3_addr_stable: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> $stable(mux_addr));

    // R2: start is a single-cycle pulse
    a_r2_start_pulse: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);
endmodule

// File: tb/acq_seq_top_tb.sv
`timescale 1ns/1ps
module acq_seq_top_tb;
    localparam int TICK    = 20;
    localparam int NORM    = 6;
    localparam int FAULT   = 10;
    localparam int MUX_N   = 4;
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 14;
    localparam int EOC_DLY = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              acq_sync = 1'b0;
    logic              fault_sync = 1'b0;
    logic [DATA_W-1:0] threshold = '0;
    logic              adc_eoc = 1'b0;
    logic [DATA_W-1:0] adc_data = '0;
    logic [MUX_N-1:0]  mux_en;
    logic [ADDR_W-1:0] mux_addr;
    logic              adc_start;
    logic              sample_rdy;
    logic              cycle_done;
    logic              fault_mode;
    logic [3:0]        sample_idx;
    logic              overrun;

    int checks = 0;
    int errors = 0;
    logic [DATA_W-1:0] adc_val = '0;
    logic adc_hold = 1'b0;
    time  t_last = 0;

    acq_seq_top #(
        .CLK_HZ(1000000), .INTERVAL_US(TICK), .NORM_SAMPLES(NORM),
        .FAULT_SAMPLES(FAULT), .MUX_N(MUX_N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_dut (
        .clk(clk), .rst(rst), .acq_sync(acq_sync), .fault_sync(fault_sync),
        .threshold(threshold), .adc_eoc(adc_eoc), .adc_data(adc_data),
        .mux_en(mux_en), .mux_addr(mux_addr), .adc_start(adc_start),
        .sample_rdy(sample_rdy), .cycle_done(cycle_done), .fault_mode(fault_mode),
        .sample_idx(sample_idx), .overrun(overrun)
    );

    always #5 clk = ~clk;

    task automatic smp;
        @(negedge clk); #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural ADC: answers each start after a short delay unless held
    initial begin
        forever begin
            smp;
            if (adc_start) begin
                repeat (EOC_DLY) smp;
                while (adc_hold) smp;
                #1; adc_data = adc_val; adc_eoc = 1'b1;
                smp;
                #1; adc_eoc = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // waits for one conversion and checks address, ready timing and counters
    task automatic do_sample(input int exp_addr, input int exp_idx, input bit exp_done,
                             input bit exp_fault, input string req, input bit chk_gap);
        do smp; while (!adc_start);
        if (chk_gap) check(($time - t_last) / 10 == TICK, "R1 tick spacing",
                           int'(($time - t_last) / 10), TICK);
        t_last = $time;
        check(mux_addr == ADDR_W'(exp_addr), "R3 address", mux_addr, exp_addr);
        do smp; while (!adc_eoc);
        check(sample_rdy == 1'b1, "R4 ready after eoc", sample_rdy, 1);
        check(sample_idx == 4'(exp_idx), req, sample_idx, exp_idx);
        check(cycle_done == exp_done, req, cycle_done, exp_done);
        check(fault_mode == exp_fault, req, fault_mode, exp_fault);
        smp;
        check(sample_rdy == 1'b0, "R4 ready one cycle", sample_rdy, 0);
    endtask

    task automatic test_reset;
        repeat (3) @(posedge clk);
        #1;
        check(mux_en == '0 && !adc_start && !sample_rdy && !cycle_done, "R11 reset outputs",
              {mux_en, adc_start, sample_rdy, cycle_done}, 0);
        check(!fault_mode && !overrun && sample_idx == '0, "R11 reset state",
              {fault_mode, overrun, sample_idx}, 0);
        smp; #1; rst = 1'b0;
    endtask

    task automatic test_sync_and_normal;
        int k = 0;
        smp; #1; acq_sync = 1'b1;
        do begin
            smp;
            k++;
            if (k == 1) acq_sync = 1'b0;
            if (k == TICK + 1) check(mux_en == '1 && !adc_start, "R2 enable first",
                                     {mux_en, adc_start}, {4'hF, 1'b0});
            if (k == TICK + 2) check(mux_en == '1 && !adc_start && mux_addr == '0,
                                     "R2 address second", mux_addr, 0);
        end while (!adc_start && k < 3 * TICK);
        check(k == TICK + 3, "R9 sync to start latency", k, TICK + 3);
        check(mux_en == '1, "R2 enable held at start", mux_en, 4'hF);
        t_last = $time;
        smp;
        check(!adc_start, "R2 start single cycle", adc_start, 0);
        do smp; while (!adc_eoc);
        check(sample_rdy && sample_idx == 4'd1 && !cycle_done, "R5 first sample",
              sample_idx, 1);
        for (int j = 1; j < NORM; j++)
            do_sample(j, (j + 1) % NORM, j == NORM - 1, 1'b0, "R5 normal cycle", 1'b1);
    endtask

    task automatic fault_cycle(input string req);
        for (int k = 0; k < FAULT; k++)
            do_sample(k % (1 << ADDR_W), (k + 1) % FAULT, k == FAULT - 1, k != FAULT - 1,
                      req, 1'b0);
    endtask

    task automatic test_threshold;
        threshold = 14'd1000;
        adc_val   = 14'd1000;
        do_sample(0, 1, 1'b0, 1'b0, "R7 equal does not trigger", 1'b0);
        adc_val   = 14'd1001;
        do_sample(1, 0, 1'b0, 1'b1, "R7 exceed enters fault", 1'b0);
        adc_val   = 14'd5;
        fault_cycle("R8 fault cycle after compare");
    endtask

    task automatic test_fault_sync;
        do_sample(0, 1, 1'b0, 1'b0, "R5 normal before fault sync", 1'b0);
        #1; fault_sync = 1'b1;
        smp; #1; fault_sync = 1'b0;
        check(fault_mode && sample_idx == '0, "R6 fault sync entry", sample_idx, 0);
        do_sample(0, 1, 1'b0, 1'b1, "R6 first fault sample", 1'b0);
        #1; fault_sync = 1'b1;
        smp; #1; fault_sync = 1'b0;
        check(fault_mode && sample_idx == 4'd1, "R6 fault sync ignored in fault",
              sample_idx, 1);
        for (int k = 1; k < FAULT; k++)
            do_sample(k % (1 << ADDR_W), (k + 1) % FAULT, k == FAULT - 1, k != FAULT - 1,
                      "R8 fault cycle after sync", 1'b0);
    endtask

    task automatic test_overrun;
        int starts = 0;
        check(!overrun, "R10 no overrun yet", overrun, 0);
        adc_hold = 1'b1;
        do smp; while (!adc_start);
        for (int i = 0; i < 3 * TICK; i++) begin
            smp;
            if (adc_start) starts++;
        end
        check(starts == 0, "R10 tick skipped", starts, 0);
        check(overrun, "R10 overrun set", overrun, 1);
        adc_hold = 1'b0;
        do smp; while (!sample_rdy);
        do smp; while (!adc_start);
        check(overrun, "R10 overrun sticky", overrun, 1);
    endtask

    initial begin
        test_reset;
        test_sync_and_normal;
        test_threshold;
        test_fault_sync;
        test_overrun;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule